// File: doc/BRIEF.md
# Sorted-Array Duplicate Compactor

This block removes repeated values from an array of 32-bit words kept in a single-port synchronous RAM. The array must already be in non-decreasing order; the block does not check this. After a start pulse it walks the array once and moves each new distinct value forward over the slots that duplicates left behind. When it finishes it raises a one-cycle done pulse and reports how many distinct values now sit at the front of the array. It needs no second buffer and no separate write pointer. A running duplicate count, kept as a byte offset, serves as the distance from each read location back to its write-back location.

The controller is a state machine with six states. ST_IDLE waits for start. On start it goes to ST_FINISH when the count is below two, and to ST_FETCH_PREV otherwise. ST_FETCH_PREV reads element i-1 and always moves on to ST_FETCH_CUR. ST_FETCH_CUR reads element i, latches the value of element i-1 and always moves on to ST_COMPARE. ST_COMPARE latches element i. When the two values match, it goes to ST_FINISH on the last index and back to ST_FETCH_PREV otherwise. When they differ, it goes to ST_STORE. ST_STORE writes element i back and goes to ST_FINISH on the last index, or to ST_FETCH_PREV otherwise. ST_FINISH drives done and always returns to ST_IDLE.

Top module: `dedup_engine`

## Requirements
- R1: After reset, done is 0, the RAM write enable is 0 and result is 0.
- R2: For a count of two or more, the scan starts at index 1 and compares each element i with element i-1, up to index count-1.
- R3: An element equal to its predecessor causes no RAM write and adds one to the duplicate count.
- R4: An element that differs from its predecessor is written to index i minus the duplicate count at that moment. Over a whole run, the number of writes is one less than the number of distinct values.
- R5: result equals the count minus the final duplicate count. The first result words of the array then hold the distinct values in their original order.
- R6: A count of 0 or 1 finishes with no memory access. done appears in the state right after the start edge, and result equals the count.
- R7: done is high for exactly one cycle. result keeps its value from done until the run that follows the next accepted start finishes.
- R8: A start pulse that arrives while a run is in progress is ignored. The run in progress keeps its base, count, result and timing.
- R9: Element k lives at byte address base + 4k. No word outside base .. base+4(count-1) is written.
- R10: Each scanned index costs 3 cycles when it is a duplicate and 4 cycles when it is written back. done is seen that many cycles after the start edge, summed over all scanned indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled in idle only) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| elem_count | input | CNT_W | Number of elements in the array |
| done | output | 1 | One-cycle completion pulse |
| result | output | CNT_W | Number of distinct values |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after the address |

## Verification
The hardest situation to reach from the ports is a start pulse that arrives in the middle of a scan. It must be ignored, and its effect can only be seen indirectly, through the result, the run length and the memory regions that are left untouched. The bench starts a long, all-distinct run and pulses start again a few cycles in, with a different base and a count of one. It then checks that the result, the run length and the second region are unchanged. Sign-boundary values, all-equal arrays and runs of mixed duplicates check the write-back offsets by reading the compacted words and the guard words on either side.

// File: rtl/dedup_pkg.sv
package dedup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_PREV,
        ST_FETCH_CUR,
        ST_COMPARE,
        ST_STORE,
        ST_FINISH
    } dd_state_e;
endpackage

// File: rtl/dedup_fsm.sv
module dedup_fsm
    import dedup_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      few_elems,
    input  logic      last_elem,
    input  logic      vals_equal,
    output dd_state_e state_q
);
    dd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = few_elems ? ST_FINISH : ST_FETCH_PREV;
            ST_FETCH_PREV: state_d = ST_FETCH_CUR;
            ST_FETCH_CUR:  state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (!vals_equal)    state_d = ST_STORE;
                else if (last_elem) state_d = ST_FINISH;
                else                state_d = ST_FETCH_PREV;
            end
            ST_STORE:      state_d = last_elem ? ST_FINISH : ST_FETCH_PREV;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // R8: a busy state never falls back to idle, whatever start does
    a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_FINISH && start) |=> (state_q != ST_IDLE));
    // R7: completion lasts one state
    a_r7_finish_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));
    // R2: leaving idle needs start
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dedup_datapath.sv
module dedup_datapath
    import dedup_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dd_state_e         state_q,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              few_elems,
    output logic              last_elem,
    output logic              vals_equal,
    output logic [CNT_W-1:0]  result
);
    localparam int OFF_W = CNT_W + 2;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  idx_q;
    logic [OFF_W-1:0]  dup_off_q;
    logic [DATA_W-1:0] prev_q;
    logic [DATA_W-1:0] cur_q;
    logic [CNT_W-1:0]  result_q;

    logic [OFF_W-1:0]  idx_off;
    logic [OFF_W-1:0]  dup_off_inc;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] store_addr;
    logic [CNT_W-1:0]  dup_cnt;
    logic [CNT_W-1:0]  dup_cnt_inc;

    assign idx_off     = {idx_q, 2'b00};
    assign dup_off_inc = dup_off_q + OFF_W'(4);
    assign dup_cnt     = dup_off_q[OFF_W-1:2];
    assign dup_cnt_inc = dup_off_inc[OFF_W-1:2];
    assign cur_addr    = base_q + ADDR_W'(idx_off);
    assign prev_addr   = cur_addr - ADDR_W'(4);
    assign store_addr  = cur_addr - ADDR_W'(dup_off_q);

    assign few_elems  = (elem_count < CNT_W'(2));
    assign last_elem  = (idx_q == count_q - CNT_W'(1));
    assign vals_equal = (mem_rdata == prev_q);
    assign result     = result_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            count_q   <= '0;
            idx_q     <= '0;
            dup_off_q <= '0;
            prev_q    <= '0;
            cur_q     <= '0;
            result_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q    <= base_addr;
                    count_q   <= elem_count;
                    idx_q     <= CNT_W'(1);
                    dup_off_q <= '0;
                    if (few_elems) result_q <= elem_count;
                end
                ST_FETCH_CUR: prev_q <= mem_rdata;
                ST_COMPARE: begin
                    cur_q <= mem_rdata;
                    if (vals_equal) begin
                        dup_off_q <= dup_off_inc;
                        idx_q     <= idx_q + CNT_W'(1);
                        if (last_elem) result_q <= count_q - dup_cnt_inc;
                    end
                end
                ST_STORE: begin
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_elem) result_q <= count_q - dup_cnt;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = cur_q;
        mem_addr  = cur_addr;
        unique case (state_q)
            ST_FETCH_PREV: mem_addr = prev_addr;
            ST_FETCH_CUR:  mem_addr = cur_addr;
            ST_STORE: begin
                mem_addr = store_addr;
                mem_we   = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: a match is never followed by a write
    a_r3_equal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && vals_equal) |=> !mem_we);
    // R4: duplicates never outnumber the scanned index
    a_r4_dup_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (dup_cnt <= idx_q));
    // R9: writes stay word-aligned relative to the base
    a_r9_aligned_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == base_q[1:0]));
    // R5: reported count never exceeds the element count
    a_r5_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> (result_q <= count_q && (count_q == '0 || result_q != '0)));
endmodule

// File: rtl/dedup_engine.sv
module dedup_engine
    import dedup_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  elem_count,
    output logic              done,
    output logic [CNT_W-1:0]  result,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    dd_state_e state_q;
    logic      few_elems;
    logic      last_elem;
    logic      vals_equal;

    dedup_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .few_elems  (few_elems),
        .last_elem  (last_elem),
        .vals_equal (vals_equal),
        .state_q    (state_q)
    );

    dedup_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .start      (start),
        .base_addr  (base_addr),
        .elem_count (elem_count),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .few_elems  (few_elems),
        .last_elem  (last_elem),
        .vals_equal (vals_equal),
        .result     (result)
    );

    assign done = (state_q == ST_FINISH);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: no write in the cycle done is raised
    a_r6_no_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);
endmodule

// File: tb/dedup_engine_tb_top.sv
`timescale 1ns/1ps
module dedup_engine_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int NVEC   = 6;

    localparam logic [31:0] VALS [0:NVEC-1][0:7] = '{
        '{32'd1, 32'd1, 32'd2, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
        '{32'hFFFFFFFB, 32'hFFFFFFFB, 32'hFFFFFFFD, 32'd0, 32'd0, 32'd0, 32'd7, 32'd9},
        '{32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd4},
        '{32'hFFFFFFFD, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'd0, 32'd1, 32'd2, 32'd3, 32'd4},
        '{32'd2, 32'd2, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
        '{32'h80000000, 32'h80000000, 32'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 32'd0, 32'd0}
    };
    localparam int CNTS [0:NVEC-1] = '{3, 8, 8, 8, 2, 5};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [CNT_W-1:0]  elem_count = '0;
    logic              done;
    logic [CNT_W-1:0]  result;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    logic [31:0] mem [0:63];
    int          wr_cnt = 0;
    int          bad_wr = 0;
    int          lo_word = 0;
    int          hi_word = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] cv [0:7];
    logic [31:0] ref_v [0:7];

    always #2.5 clk = ~clk;

    dedup_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .elem_count(elem_count), .done(done), .result(result),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[7:2]];
        if (mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
            if (int'(mem_addr[7:2]) < lo_word || int'(mem_addr[7:2]) > hi_word)
                bad_wr = bad_wr + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int k = 0; k < 64; k++) mem[k] = 32'hA5A50000 + k;
    endtask

    // runs one case on cv[0..cnt-1] at word bw; optional stray start at cycle 2
    task automatic run_case(input int bw, input int cnt, input bit stray, input string tag);
        int ek;
        int exp_lat;
        int n;
        int w0;
        logic [31:0] g_lo;
        logic [31:0] g_hi;
        logic [31:0] g_stray;
        logic [CNT_W-1:0] r_hold;
        ek = 0;
        exp_lat = 0;
        for (int j = 0; j < cnt; j++) begin
            mem[bw + j] = cv[j];
            if (j == 0 || cv[j] != cv[j-1]) begin
                ref_v[ek] = cv[j];
                ek++;
                if (j > 0) exp_lat += 4;
            end else begin
                exp_lat += 3;
            end
        end
        g_lo = mem[bw - 1];
        g_hi = mem[bw + cnt];
        g_stray = mem[60];
        lo_word = bw;
        hi_word = (cnt > 0) ? bw + cnt - 1 : bw - 1;
        bad_wr = 0;
        @(negedge clk);
        start = 1'b1;
        base_addr = ADDR_W'(bw * 4);
        elem_count = CNT_W'(cnt);
        w0 = wr_cnt;
        @(posedge clk);
        #1;
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            if (stray && n == 2) begin
                start = 1'b1;
                base_addr = ADDR_W'(60 * 4);
                elem_count = CNT_W'(1);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            #1;
            n++;
        end
        start = 1'b0;
        chk(done, {tag, " watchdog/done seen"}, done, 1);
        chk(result == CNT_W'(ek), {tag, " R5 result"}, result, ek);
        chk(n == exp_lat, {tag, " R10 cycles to done"}, n, exp_lat);
        chk(wr_cnt - w0 == ((ek > 0) ? ek - 1 : 0), {tag, " R4 write count"}, wr_cnt - w0, (ek > 0) ? ek - 1 : 0);
        chk(bad_wr == 0, {tag, " R9 write range"}, bad_wr, 0);
        for (int j = 0; j < ek; j++)
            chk(mem[bw + j] == ref_v[j], {tag, " R5 compacted word"}, mem[bw + j], ref_v[j]);
        chk(mem[bw - 1] == g_lo && mem[bw + cnt] == g_hi, {tag, " R9 guard words"}, mem[bw + cnt], g_hi);
        if (stray) chk(mem[60] == g_stray, {tag, " R8 stray region untouched"}, mem[60], g_stray);
        r_hold = result;
        @(posedge clk);
        #1;
        chk(!done, {tag, " R7 done one cycle"}, done, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(result == r_hold, {tag, " R7 result held"}, result, r_hold);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        fill_mem();
        repeat (3) @(posedge clk);
        #1;
        chk(!done, "R1 done after reset", done, 0);
        chk(!mem_we, "R1 write enable after reset", mem_we, 0);
        chk(result == '0, "R1 result after reset", result, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // table-driven vectors (R2 R3 R4 R5 R9 R10)
        for (int v = 0; v < NVEC; v++) begin
            fill_mem();
            for (int j = 0; j < 8; j++) cv[j] = VALS[v][j];
            run_case(4 + v * 9, CNTS[v], 1'b0, $sformatf("vec%0d", v));
        end

        // R6: counts of zero and one
        fill_mem();
        cv[0] = 32'd77;
        run_case(20, 0, 1'b0, "R6 count0");
        fill_mem();
        cv[0] = 32'd77;
        run_case(20, 1, 1'b0, "R6 count1");

        // R8: stray start during an all-distinct scan
        fill_mem();
        for (int j = 0; j < 8; j++) cv[j] = 32'd10 + 32'(j);
        run_case(30, 8, 1'b1, "R8 busy start");

        // R3: long run of equal words then a change
        fill_mem();
        for (int j = 0; j < 8; j++) cv[j] = (j < 7) ? 32'hFFFFFFFF : 32'd0;
        run_case(40, 8, 1'b0, "R3 equal run");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule